// File: doc/BRIEF.md
# Receive DIP-4 Alignment Monitor

This block sits on the receive data path of a SPI-4.2-style link, after word deskew. It takes one 16-bit word per clock, together with a flag that marks control words. Until it has recognised the training sequence, it treats every word as noise. Once it has locked, it computes a four-bit diagonal interleaved parity over each run of words that a control word closes. It compares that parity with the check field carried in the closing control word.

A correct check brings the link into sync and drives the active-low alignment status to 0. A run of failed checks longer than a programmable threshold takes the link out of sync and sends the block back to the training search. Losing deskew or applying the receive reset does the same. A loss of sync after the link was good leaves the alignment-off bit latched at 1 until a write-one-to-clear pulse arrives. The sync output feeds the status generator, which keeps sending its framing pattern while sync is low.

Top module: `rx_dip4_align_mon`

## Requirements
- R1: During and right after the synchronous active-low reset, `align_off_o` is 1 and `sync_o` is 0.
- R2: Before the training sequence has been recognised, no control word is parity-checked and `sync_o` stays 0, whatever check values arrive.
- R3: The training sequence is recognised in three steps. First comes an idle control word: `ctrl_i`=1 with bits 15:4 all zero. Further idle words may follow it. Next comes the training control word: `ctrl_i`=1, value 16'h0FFF. The word right after that must be the training data word: `ctrl_i`=0, value 16'hF000. The block locks after that training data word. Any other order returns the search to its start.
- R4: The parity is computed as follows. An accumulator clears to 0 on every control word. Each data word w updates it as acc = rotate-left-by-one(acc) XOR w. The closing control word is folded in the same way with its bits 3:0 forced to zero. The expected value is the XOR of the accumulator's four nibbles, and it is compared with bits 3:0 of that control word. Every control word received while locked is checked, except the training control word. The first passing check sets `sync_o` to 1. If no loss of sync is latched, it also drives `align_off_o` to 0.
- R5: If the number of consecutive failed checks exceeds `err_thr_i`, then `sync_o` drops to 0 and `align_off_o` goes to 1. The block then returns to the training search, so later correct frames give no sync until the block retrains. With a threshold of 0, a single failed check is enough.
- R6: A passing check resets the count of consecutive failures to zero.
- R7: A cycle with `deskew_done_i` low drops sync and returns the block to the training search.
- R8: Each loss of sync from an in-sync state latches `align_off_o` at 1, even after the link resyncs. A cycle with `align_clr_i`=1 clears that latch. The clear has no visible effect while `sync_o` is 0.
- R9: Training control and data words received while locked cause no parity failure.
- R10: After the receive reset is released, the block starts again from the training search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low receive reset |
| deskew_done_i | input | 1 | Word deskew complete |
| ctrl_i | input | 1 | Marks the current word as a control word |
| word_i | input | 16 | Received word |
| err_thr_i | input | 4 | Allowed consecutive parity failures |
| align_clr_i | input | 1 | Write-one-to-clear for the latched alignment loss |
| align_off_o | output | 1 | Alignment status, 0 means link good |
| sync_o | output | 1 | Link in sync, for the status generator |

## Verification
The assertions take for granted that exactly one word arrives per clock, with no idle gaps. They also assume that the threshold is changed only while no failures are being counted, since the counter bound is checked against the current threshold. The stimulus changes `err_thr_i` only between scenarios, while the link is synced with a zero failure count or is idle. It drives every input at the falling edge, with one word per cycle. Parity values come from a bench model of the accumulator, so both correct and deliberately corrupted check fields are exact.

// File: rtl/rx_align_pkg.sv
// Package: shared constants, state type and helpers for the DIP-4 monitor.
// Assumes 16-bit link words carrying a 4-bit check field in bits 3:0.
package rx_align_pkg;
    localparam int WORD_W = 16;
    localparam int DIP_W  = 4;
    localparam int FOLDS  = WORD_W / DIP_W;
    localparam logic [WORD_W-1:0] TRAIN_CTL = 16'h0FFF;
    localparam logic [WORD_W-1:0] TRAIN_DAT = 16'hF000;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_IDLE,
        ST_TCTL,
        ST_LOCK
    } hunt_st_e;

    // One-bit left rotation used by the diagonal parity.
    function automatic logic [WORD_W-1:0] rotl1(input logic [WORD_W-1:0] a);
        return {a[WORD_W-2:0], a[WORD_W-1]};
    endfunction
endpackage

// File: rtl/rx_train_hunt.sv
// Training search: hunts for idle, training control, training data and then
// holds lock until deskew is lost or the error monitor reports a drop.
// Assumes one word per clock.
module rx_train_hunt
    import rx_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deskew_i,
    input  logic              ctrl_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              drop_i,
    output logic              locked_o
);
    hunt_st_e state_q, state_d;
    logic is_idle, is_tctl, is_tdat;

    // Classify the current word.
    always_comb begin
        is_idle = ctrl_i && (word_i[WORD_W-1:DIP_W] == '0);
        is_tctl = ctrl_i && (word_i == TRAIN_CTL);
        is_tdat = !ctrl_i && (word_i == TRAIN_DAT);
    end

    // Next state of the training search.
    always_comb begin
        state_d = state_q;
        if (!deskew_i || drop_i) begin
            state_d = ST_HUNT;
        end else begin
            case (state_q)
                ST_HUNT: if (is_idle) state_d = ST_IDLE;
                ST_IDLE: begin
                    if (is_tctl)       state_d = ST_TCTL;
                    else if (!is_idle) state_d = ST_HUNT;
                end
                ST_TCTL: state_d = is_tdat ? ST_LOCK : (is_idle ? ST_IDLE : ST_HUNT);
                default: state_d = ST_LOCK;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    assign locked_o = (state_q == ST_LOCK);

    // R3
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(state_q == ST_TCTL));

    // R7
    deskew_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !deskew_i |=> !locked_o);
endmodule

// File: rtl/rx_dip4_check.sv
// Diagonal interleaved parity: accumulates words between control words and
// compares the folded result with the check field of the closing control word.
// Assumes the check field sits in the low DIP_W bits of a control word.
module rx_dip4_check
    import rx_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              good_o
);
    logic [WORD_W-1:0] acc_q, fin;
    logic [DIP_W-1:0]  expect_dip;

    // Fold the closing word, with its check field zeroed, into the running value.
    always_comb begin
        fin = rotl1(acc_q) ^ {word_i[WORD_W-1:DIP_W], {DIP_W{1'b0}}};
        expect_dip = '0;
        for (int k = 0; k < FOLDS; k++) begin
            expect_dip = expect_dip ^ fin[k*DIP_W +: DIP_W];
        end
        good_o = (expect_dip == word_i[DIP_W-1:0]);
    end

    // Running accumulator, restarted by every control word.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_i) acc_q <= '0;
        else                  acc_q <= rotl1(acc_q) ^ word_i;
    end

    // R4
    acc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i |=> acc_q == '0);
endmodule

// File: rtl/rx_dip4_errmon.sv
// Error monitor: counts consecutive failed checks, owns the sync flag and the
// sticky loss latch. Assumes err_thr_i changes only while no failures are counted.
module rx_dip4_errmon #(
    parameter int TH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            deskew_i,
    input  logic            chk_en_i,
    input  logic            chk_good_i,
    input  logic [TH_W-1:0] thr_i,
    input  logic            clr_i,
    output logic            drop_o,
    output logic            sync_o,
    output logic            trip_o
);
    logic [TH_W-1:0] cnt_q;
    logic [TH_W:0]   cnt_inc;
    logic            sync_q, trip_q, lose;

    // Detect a failure run that goes past the threshold.
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        drop_o  = chk_en_i && !chk_good_i && (cnt_inc > {1'b0, thr_i});
        lose    = drop_o || !deskew_i;
    end

    // Failure counter and sync flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sync_q <= 1'b0;
        end else if (lose) begin
            cnt_q  <= '0;
            sync_q <= 1'b0;
        end else if (chk_en_i) begin
            if (chk_good_i) begin
                cnt_q  <= '0;
                sync_q <= 1'b1;
            end else begin
                cnt_q <= cnt_inc[TH_W-1:0];
            end
        end
    end

    // Sticky latch of a loss of sync; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              trip_q <= 1'b0;
        else if (lose && sync_q) trip_q <= 1'b1;
        else if (clr_i)          trip_q <= 1'b0;
    end

    assign sync_o = sync_q;
    assign trip_o = trip_q;

    // R4
    sync_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_q) |-> $past(chk_en_i && chk_good_i));

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(thr_i) |-> cnt_q <= thr_i);

    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en_i && chk_good_i |=> cnt_q == '0);

    // R8
    trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(trip_q) && !$past(clr_i) |-> trip_q);

    // R8
    trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_q) |-> $past(sync_q));
endmodule

// File: rtl/rx_dip4_align_mon.sv
// Top: receive alignment monitor. Hunts for training, then checks DIP-4 on
// every non-training control word and reports sync and active-low alignment.
// Assumes one deskewed word per clock.
module rx_dip4_align_mon
    import rx_align_pkg::*;
#(
    parameter int TH_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deskew_done_i,
    input  logic              ctrl_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [TH_W-1:0]   err_thr_i,
    input  logic              align_clr_i,
    output logic              align_off_o,
    output logic              sync_o
);
    logic locked, good, chk_en, drop, sync_w, trip_w;

    rx_train_hunt u_hunt (
        .clk      (clk),
        .rst_n    (rst_n),
        .deskew_i (deskew_done_i),
        .ctrl_i   (ctrl_i),
        .word_i   (word_i),
        .drop_i   (drop),
        .locked_o (locked)
    );

    rx_dip4_check u_dip (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_i (ctrl_i),
        .word_i (word_i),
        .good_o (good)
    );

    // Check only while locked, and never on the training control word.
    assign chk_en = locked && ctrl_i && (word_i != TRAIN_CTL);

    rx_dip4_errmon #(.TH_W(TH_W)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .deskew_i   (deskew_done_i),
        .chk_en_i   (chk_en),
        .chk_good_i (good),
        .thr_i      (err_thr_i),
        .clr_i      (align_clr_i),
        .drop_o     (drop),
        .sync_o     (sync_w),
        .trip_o     (trip_w)
    );

    assign sync_o      = sync_w;
    assign align_off_o = !sync_w || trip_w;

    // R2
    sync_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> locked);

    // R5
    drop_unsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !sync_o && !locked);
endmodule

// File: tb/test_rx_dip4_align_mon.sv
module test_rx_dip4_align_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        deskew = 1'b0;
    logic        ctrl = 1'b0;
    logic [15:0] word = 16'h0;
    logic [3:0]  thr = 4'd2;
    logic        clr = 1'b0;
    logic        align_off, sync;

    int tests = 0;
    int fails = 0;
    logic [15:0] macc = 16'h0;

    always #10 clk = ~clk;

    rx_dip4_align_mon i_rx_dip4_align_mon (
        .clk(clk), .rst_n(rst_n), .deskew_done_i(deskew), .ctrl_i(ctrl),
        .word_i(word), .err_thr_i(thr), .align_clr_i(clr),
        .align_off_o(align_off), .sync_o(sync)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {align_off,sync} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rl(input logic [15:0] a);
        return {a[14:0], a[15]};
    endfunction

    // Drive one word at the falling edge and wait for the next falling edge.
    task automatic put(input logic [15:0] w, input logic c);
        word = w;
        ctrl = c;
        @(negedge clk);
        if (c) macc = 16'h0;
        else   macc = rl(macc) ^ w;
    endtask

    task automatic train();
        put(16'h0005, 1'b1);
        put(16'h0FFF, 1'b1);
        put(16'hF000, 1'b0);
    endtask

    // n data words, then a closing control word with a right or wrong check field.
    task automatic frame(input int n, input logic [7:0] seed, input logic bad);
        logic [15:0] f;
        logic [3:0]  d;
        logic [11:0] hdr;
        for (int i = 0; i < n; i++) put({seed, 8'(i * 37 + 11)}, 1'b0);
        hdr = {4'h8, seed};
        f = rl(macc) ^ {hdr, 4'h0};
        d = f[15:12] ^ f[11:8] ^ f[7:4] ^ f[3:0];
        put({hdr, d ^ {3'b0, bad}}, 1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        put(16'h0, 1'b0);
        put(16'h0, 1'b0);
        rst_n = 1'b1;
        macc = 16'h0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset", {align_off, sync}, 2'b10);
    endtask

    task automatic t_ignore();
        deskew = 1'b1;
        thr = 4'd0;
        frame(3, 8'h11, 1'b0);
        check("R2 good frame before training", {align_off, sync}, 2'b10);
        frame(2, 8'h12, 1'b1);
        frame(2, 8'h13, 1'b0);
        check("R2 bad frame before training", {align_off, sync}, 2'b10);
        put(16'h0FFF, 1'b1);
        put(16'hF000, 1'b0);
        frame(2, 8'h14, 1'b0);
        check("R3 training without idle", {align_off, sync}, 2'b10);
        put(16'h0000, 1'b1);
        put(16'h0FFF, 1'b1);
        put(16'h1234, 1'b0);
        frame(2, 8'h15, 1'b0);
        check("R3 wrong training data word", {align_off, sync}, 2'b10);
    endtask

    task automatic t_sync();
        train();
        check("R3 locked but no check yet", {align_off, sync}, 2'b10);
        frame(4, 8'h21, 1'b0);
        check("R4 first good check", {align_off, sync}, 2'b01);
    endtask

    task automatic t_thresh();
        thr = 4'd2;
        frame(1, 8'h31, 1'b1);
        frame(2, 8'h32, 1'b1);
        check("R5 two errors at threshold 2", {align_off, sync}, 2'b01);
        frame(3, 8'h33, 1'b0);
        frame(1, 8'h34, 1'b1);
        frame(1, 8'h35, 1'b1);
        check("R6 count restarted by good check", {align_off, sync}, 2'b01);
        frame(1, 8'h36, 1'b1);
        check("R5 third error drops sync", {align_off, sync}, 2'b10);
        frame(2, 8'h37, 1'b0);
        check("R5 back to training search", {align_off, sync}, 2'b10);
    endtask

    task automatic t_sticky();
        train();
        frame(2, 8'h41, 1'b0);
        check("R8 resync keeps latched loss", {align_off, sync}, 2'b11);
        clr = 1'b1;
        put(16'h0, 1'b0);
        clr = 1'b0;
        check("R8 clear gives link good", {align_off, sync}, 2'b01);
        thr = 4'd0;
        frame(1, 8'h42, 1'b1);
        check("R5 threshold 0 single error", {align_off, sync}, 2'b10);
        clr = 1'b1;
        put(16'h0, 1'b0);
        clr = 1'b0;
        check("R8 clear while out of sync", {align_off, sync}, 2'b10);
        train();
        frame(2, 8'h43, 1'b0);
        check("R8 latch was cleared while out of sync", {align_off, sync}, 2'b01);
    endtask

    task automatic t_train_locked();
        for (int i = 0; i < 3; i++) begin
            put(16'h0FFF, 1'b1);
            put(16'hF000, 1'b0);
        end
        check("R9 training words while locked", {align_off, sync}, 2'b01);
        frame(2, 8'h51, 1'b0);
        check("R9 frame after training words", {align_off, sync}, 2'b01);
    endtask

    task automatic t_deskew();
        deskew = 1'b0;
        put(16'h0, 1'b1);
        deskew = 1'b1;
        check("R7 deskew loss", {align_off, sync}, 2'b10);
        frame(2, 8'h61, 1'b0);
        check("R7 needs retraining", {align_off, sync}, 2'b10);
        clr = 1'b1;
        train();
        clr = 1'b0;
        frame(2, 8'h62, 1'b0);
        check("R7 retrained", {align_off, sync}, 2'b01);
    endtask

    task automatic t_rst();
        do_reset();
        check("R10 reset while synced", {align_off, sync}, 2'b10);
        frame(2, 8'h71, 1'b0);
        check("R10 search restarts after reset", {align_off, sync}, 2'b10);
        train();
        frame(3, 8'h72, 1'b0);
        check("R10 sync after retraining", {align_off, sync}, 2'b01);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_ignore();
        t_sync();
        t_thresh();
        t_sticky();
        t_train_locked();
        t_deskew();
        t_rst();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule